// File: doc/BRIEF.md
# Dual-Mode Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It takes the local-oscillator clock, divides it by a programmed ratio and emits a single-cycle pulse each time a division period completes. The phase detector compares that pulse against its reference.

Two select bits pick one of three counting paths:

- **Prescaled path.** A divide-by-two stage feeds a dual-modulus (16/17) swallow structure. The real ratio is twice the programmed value.
- **Direct swallow path.** The input clock drives the swallow structure with no prescaler.
- **Short direct path.** The input clock drives a plain 12-bit programmable counter.

Each path clamps the programmed value to its own legal range. The divider picks up a new ratio or path only when the running period finishes, so the phase detector never sees a truncated period.

Top module: `swallow_divider`

## Requirements
- R1: With `band_hi`=1, pulses occur every 2·N input cycles, where N is the clamped swallow value.
- R2: With `band_hi`=0 and `swallow_en`=1, pulses occur every N input cycles through the swallow structure.
- R3: With `band_hi`=0 and `swallow_en`=0, pulses occur every N input cycles through the short counter.
- R4: In both swallow paths, a `div_word` below 256 acts as 256, and values from 256 to 65535 are used as given.
- R5: In the short path, a `div_word` below 4 acts as 4, and a value above 4096 acts as 4096.
- R6: `div_pulse` is high for exactly one input cycle per period.
- R7: A change of `div_word`, `band_hi` or `swallow_en` mid-period leaves the running period length untouched. The new setting governs from the following period on.
- R8: Reset is synchronous and active high. `div_pulse` is low after a clock edge with reset high. After reset is released, the first pulse follows the Nth (or 2·Nth) clock edge.
- R9: The swallow structure splits N into a 17-count phase repeated N mod 16 times, followed by 16-count phases, for a total of N/16 phases. The period is exact for both swallow count 0 and swallow count 15.
- R10: With `band_hi`=1, the value of `swallow_en` has no effect on the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local-oscillator input clock |
| rst | input | 1 | Synchronous reset, active high |
| div_word | input | 16 | Programmed division value |
| band_hi | input | 1 | 1 selects the divide-by-two prescaled swallow path |
| swallow_en | input | 1 | With band_hi=0: 1 selects direct swallow, 0 selects the short counter |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |

## Verification
The bench targets the swallow split at its extremes: value 271, which gives a swallow count of 15 and the minimum main count, and value 512, which gives a swallow count of 0. A design with the 17/16 phase order or the swallow-counter reload wrong would drift by one or more cycles per period.

The clamp limits are checked at both edges of each range, including 65535. A design clamping against the wrong limit would produce periods such as 10 or 9000 cycles.

A mid-period change of ratio and a mid-period change of path are both applied. A design that loads settings immediately would emit a short or misplaced pulse. Reset is applied in the middle of a run; a design that leaves counters partly cleared would fire early after release.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int WORD_W  = 16,
  parameter int PRE_W   = 4,
  parameter int DIR_W   = 12,
  parameter int DIR_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] div_word,
  input  logic              band_hi,
  input  logic              swallow_en,
  output logic              div_pulse
);
  localparam int MAIN_W = WORD_W - PRE_W;
  localparam logic [WORD_W-1:0] SW_MIN_W  = WORD_W'(2 ** (2 * PRE_W));
  localparam logic [WORD_W-1:0] DIR_MIN_W = WORD_W'(DIR_MIN);
  localparam logic [WORD_W-1:0] DIR_MAX_W = WORD_W'(2 ** DIR_W);
  localparam logic [PRE_W:0]    TOP_LONG  = (PRE_W+1)'(2 ** PRE_W);
  localparam logic [PRE_W:0]    TOP_SHORT = (PRE_W+1)'(2 ** PRE_W - 1);

  // clamped next settings
  logic [WORD_W-1:0] n_sw, n_dir, n_dir_m1;
  logic [PRE_W-1:0]  nx_a;
  logic [MAIN_W-1:0] nx_mlast;
  logic [DIR_W-1:0]  nx_dlast;

  assign n_sw     = (div_word < SW_MIN_W) ? SW_MIN_W : div_word;
  assign n_dir    = (div_word < DIR_MIN_W) ? DIR_MIN_W :
                    (div_word > DIR_MAX_W) ? DIR_MAX_W : div_word;
  assign n_dir_m1 = n_dir - 1'b1;
  assign nx_a     = n_sw[PRE_W-1:0];
  assign nx_mlast = n_sw[WORD_W-1:PRE_W] - 1'b1;
  assign nx_dlast = n_dir_m1[DIR_W-1:0];

  // active settings, loaded only at a period boundary
  logic              cfg_dv, cfg_sw;
  logic [MAIN_W-1:0] cfg_mlast;
  logic [DIR_W-1:0]  cfg_dlast;

  // counters
  logic              half;
  logic [PRE_W:0]    pre_c;
  logic [PRE_W-1:0]  sw_left;
  logic [MAIN_W-1:0] main_c;
  logic [DIR_W-1:0]  dir_c;

  logic tick, pre_last, period_end;

  assign tick       = cfg_dv ? half : 1'b1;
  assign pre_last   = pre_c == ((sw_left != '0) ? TOP_LONG : TOP_SHORT);
  assign period_end = tick && (cfg_sw ? (pre_last && main_c == cfg_mlast)
                                      : (dir_c == cfg_dlast));

  always_ff @(posedge clk) begin
    if (rst || period_end) begin
      cfg_dv    <= band_hi;
      cfg_sw    <= band_hi | swallow_en;
      cfg_mlast <= nx_mlast;
      cfg_dlast <= nx_dlast;
      sw_left   <= nx_a;
      half      <= 1'b0;
      pre_c     <= '0;
      main_c    <= '0;
      dir_c     <= '0;
      div_pulse <= !rst;
    end else begin
      div_pulse <= 1'b0;
      half      <= ~half;
      if (tick) begin
        if (cfg_sw) begin
          if (pre_last) begin
            pre_c  <= '0;
            main_c <= main_c + 1'b1;
            if (sw_left != '0) sw_left <= sw_left - 1'b1;
          end else begin
            pre_c <= pre_c + 1'b1;
          end
        end else begin
          dir_c <= dir_c + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int WORD_W  = 16,
  parameter int DIR_MIN = 4
) (
  input logic clk,
  input logic rst,
  input logic div_pulse
);
  localparam int GAP_W = WORD_W + 2;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(2 * (2 ** WORD_W - 1));
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(DIR_MIN - 1);

  logic             rst_q;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || div_pulse) gap <= '0;
    else if (gap != '1)   gap <= gap + 1'b1;
  end

  p_single_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse)
    else $error("pulse wider than one cycle");

  always @(posedge clk) begin
    if (rst_q)
      p_quiet_after_reset_r8: assert (!div_pulse)
        else $error("pulse right after reset");
    if (!rst && !rst_q && div_pulse)
      p_no_short_period_r7: assert (gap >= GAP_MIN)
        else $error("period shorter than legal minimum");
    if (!rst && !rst_q)
      p_no_long_period_r1: assert (gap <= GAP_MAX)
        else $error("period longer than legal maximum");
  end
endmodule

bind swallow_divider swallow_divider_chk #(.WORD_W(WORD_W), .DIR_MIN(DIR_MIN)) u_chk (
  .clk(clk), .rst(rst), .div_pulse(div_pulse));

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] div_word = 16'd300;
  logic        band_hi = 1'b0;
  logic        swallow_en = 1'b0;
  logic        div_pulse;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rst(rst), .div_word(div_word),
    .band_hi(band_hi), .swallow_en(swallow_en), .div_pulse(div_pulse));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_in(input int w, input bit dv, input bit sp);
    div_word = 16'(w); band_hi = dv; swallow_en = sp;
  endtask

  // R8: reset drives pulse low; release at a negedge so next posedge is edge 1
  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(div_pulse == 1'b0, "R8", "pulse during reset", int'(div_pulse), 0);
    rst = 1'b0;
  endtask

  task automatic run_train(input int w, input bit dv, input bit sp,
                           input int per, input int nper, input string req);
    int first = 0, second = 0, cnt = 0, dbl = 0;
    bit prev = 1'b0;
    set_in(w, dv, sp);
    do_reset();
    for (int c = 1; c <= per * nper; c++) begin
      @(posedge clk); @(negedge clk);
      if (div_pulse) begin
        cnt++;
        if (cnt == 1) first = c;
        if (cnt == 2) second = c;
        if (prev) dbl++;
      end
      prev = div_pulse;
    end
    check(first == per, req, "first pulse cycle", first, per);
    if (nper >= 2) check(second == 2 * per, req, "second pulse cycle", second, 2 * per);
    check(cnt == nper, req, "pulse count", cnt, nper);
    check(dbl == 0, "R6", "back-to-back pulses", dbl, 0);
  endtask

  // R7: settings change mid-period; expected pulse cycles listed explicitly
  task automatic run_change(input int w0, input bit dv0, input bit sp0,
                            input int at, input int w1, input bit dv1, input bit sp1,
                            input int last, input int e1, input int e2,
                            input int e3, input int e4);
    int miss = 0, first_bad = 0;
    set_in(w0, dv0, sp0);
    do_reset();
    for (int c = 1; c <= last; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == at) set_in(w1, dv1, sp1);
      if (div_pulse != (c == e1 || c == e2 || c == e3 || c == e4)) begin
        if (miss == 0) first_bad = c;
        miss++;
      end
    end
    check(miss == 0, "R7", "cycles with wrong pulse (first shown)", first_bad, 0);
  endtask

  task automatic run_mid_reset();
    set_in(50, 1'b0, 1'b0);
    do_reset();
    repeat (30) @(posedge clk);
    run_train(50, 1'b0, 1'b0, 50, 1, "R8");
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    run_train(300,   1'b1, 1'b0, 600,   2, "R1");
    run_train(300,   1'b1, 1'b1, 600,   2, "R10");
    run_train(1000,  1'b0, 1'b1, 1000,  2, "R2");
    run_train(271,   1'b0, 1'b1, 271,   2, "R9");
    run_train(512,   1'b0, 1'b1, 512,   2, "R9");
    run_train(10,    1'b0, 1'b1, 256,   2, "R4");
    run_train(10,    1'b1, 1'b0, 512,   2, "R4");
    run_train(65535, 1'b0, 1'b1, 65535, 1, "R4");
    run_train(100,   1'b0, 1'b0, 100,   3, "R3");
    run_train(4,     1'b0, 1'b0, 4,     3, "R3");
    run_train(1,     1'b0, 1'b0, 4,     3, "R5");
    run_train(9000,  1'b0, 1'b0, 4096,  2, "R5");
    run_change(10, 1'b0, 1'b0, 13, 20,  1'b0, 1'b0, 62,  10, 20, 40, 60);
    run_change(10, 1'b0, 1'b0, 13, 300, 1'b1, 1'b0, 625, 10, 20, 620, -1);
    run_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule